// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This controller sits on the platform side of a processor and walks it through a nested set of low-power states: running, Stop-Grant, Sleep and Deep Sleep. An upstream register holds a 2-bit target level. The sequencer moves toward that level one step at a time, and only ever between neighbouring states. It drives three active-low request lines (stop-clock, sleep, deep sleep) and an enable for the processor bus clock. It reports the settled state on a 2-bit code and pulses `done` each time a step completes.

The sequencer counts reference clock cycles for two timed windows. The first is the delay before the bus clock is gated after Deep Sleep is entered. The second is the PLL settling wait after Deep Sleep is left; by default this is 1500 cycles, which is 15 µs at 100 MHz. While the processor cannot answer, the sequencer holds back snoop and interrupt requests, flags each one as a protocol error, and releases it once the processor is back in a state that can take it. A processor reset requested from Sleep bypasses Stop-Grant: the sleep and stop-clock lines are released in the same cycle that the reset output rises.

Top module: `lp_state_seq`

## Requirements
- R1: When the target level `pwr_req` is nonzero (00 run, 01 Stop-Grant, 10 Sleep, 11 Deep Sleep) and the sequencer is in the running state, `stop_clk_req_n` goes low on the next cycle. Stop-Grant (`state_code` 00) is reached only on the cycle after `stop_ack` is seen high. Until then `state_code` reads 11 and `running` reads 0.
- R2: Sleep (`sleep_req_n` low, `state_code` 01) is entered only from Stop-Grant, when `pwr_req[1]` is 1. Deep Sleep (`deep_req_n` low, `state_code` 10) is entered only from Sleep, when `pwr_req` is 11. At any time, `deep_req_n` low implies `sleep_req_n` low, and `sleep_req_n` low implies `stop_clk_req_n` low.
- R3: When `pwr_req` leaves 11 during Deep Sleep, `deep_req_n` and `bus_clk_en` both go high on the next cycle. `state_code` then reads 11 for exactly `PLL_CYC` cycles before it reads 01.
- R4: With `cfg_clk_stop` = 1, `bus_clk_en` falls `STOP_DLY` cycles after `deep_req_n` falls. With `cfg_clk_stop` = 0 it stays high throughout Deep Sleep. It is never low while `deep_req_n` is high.
- R5: While `sleep_req_n` is low, or while processor reset is held, `snoop_fwd` and `irq_fwd` stay 0. A `snoop_req` or `irq_req` in that period sets `proto_err` on the next cycle. The held request is forwarded in the first cycle back in a running or Stop-Grant state.
- R6: If `reset_req` is high in Sleep, then on the next cycle `cpu_reset` is 1, `stop_clk_req_n` and `sleep_req_n` are 1, and `state_code` is 11. When `reset_req` falls, the sequencer goes directly to the running state.
- R7: A request for Deep Sleep made during the PLL settling wait does not shorten that wait. It takes effect on the cycle after Sleep is reached.
- R8: `state_code` reads 00 in Stop-Grant, 01 in Sleep, 10 in Deep Sleep and 11 in any other state. `running` is 1 only in the running state. `done` is high for exactly the first cycle of each newly reached running, Stop-Grant, Sleep or Deep Sleep state. After `rst_n` the sequencer is running, with all request lines high and `bus_clk_en` 1.
- R9: From Sleep, a `pwr_req` with bit 1 clear returns the sequencer to Stop-Grant. From Stop-Grant, `pwr_req` = 00 returns it to running and raises `stop_clk_req_n`.
- R10: `reset_req` is ignored during Deep Sleep and during the PLL settling wait. `cpu_reset` stays 0 and the state code is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rst_n | input | 1 | asynchronous active-low reset of the sequencer |
| pwr_req | input | 2 | target level: 00 run, 01 Stop-Grant, 10 Sleep, 11 Deep Sleep |
| stop_ack | input | 1 | processor acknowledges the stop-clock request |
| reset_req | input | 1 | platform request to reset the processor |
| cfg_clk_stop | input | 1 | 1 = gate the bus clock in Deep Sleep |
| snoop_req | input | 1 | snoop request from the bus |
| irq_req | input | 1 | interrupt request from the bus |
| stop_clk_req_n | output | 1 | active-low stop-clock request |
| sleep_req_n | output | 1 | active-low sleep request |
| deep_req_n | output | 1 | active-low deep-sleep request |
| bus_clk_en | output | 1 | bus clock enable |
| cpu_reset | output | 1 | processor reset |
| snoop_fwd | output | 1 | snoop forwarded to the processor |
| irq_fwd | output | 1 | interrupt forwarded to the processor |
| proto_err | output | 1 | a snoop or interrupt arrived while blocked |
| state_code | output | 2 | settled state code |
| running | output | 1 | processor is in the running state |
| done | output | 1 | one-cycle pulse when a step completes |

## Verification
The assertions assume that `pwr_req`, `stop_ack` and `reset_req` are synchronous to `clk` and held stable between clock edges. They also assume that `STOP_DLY` is at least 1. The stimulus changes inputs only on falling edges. Each request is held until the step it triggers is observed, and snoop or interrupt requests are pulsed for a single cycle. Deep Sleep exits are run with the full default settling count, and the clock-stop option is tested both on and off.

// File: rtl/lp_state_seq.sv
module lp_state_seq #(
  parameter int PLL_CYC  = 1500,
  parameter int STOP_DLY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_req,
  input  logic       stop_ack,
  input  logic       reset_req,
  input  logic       cfg_clk_stop,
  input  logic       snoop_req,
  input  logic       irq_req,
  output logic       stop_clk_req_n,
  output logic       sleep_req_n,
  output logic       deep_req_n,
  output logic       bus_clk_en,
  output logic       cpu_reset,
  output logic       snoop_fwd,
  output logic       irq_fwd,
  output logic       proto_err,
  output logic [1:0] state_code,
  output logic       running,
  output logic       done
);
  localparam int MAXC = (PLL_CYC > STOP_DLY) ? PLL_CYC : STOP_DLY;
  localparam int CW   = $clog2(MAXC) + 1;

  typedef enum logic [2:0] {RUN, SGW, SG, SLP, DSL, EXT, RST} st_t;
  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic gated, snp_pend, irq_pend;

  always_comb begin
    nxt = st;
    case (st)
      RUN: if (reset_req) nxt = RST; else if (pwr_req != 2'b00) nxt = SGW;
      SGW: if (reset_req) nxt = RST; else if (stop_ack) nxt = SG;
      SG:  if (reset_req) nxt = RST; else if (pwr_req == 2'b00) nxt = RUN;
           else if (pwr_req[1]) nxt = SLP;
      SLP: if (reset_req) nxt = RST; else if (pwr_req == 2'b11) nxt = DSL;
           else if (!pwr_req[1]) nxt = SG;
      DSL: if (pwr_req != 2'b11) nxt = EXT;
      EXT: if (cnt == '0) nxt = SLP;
      RST: if (!reset_req) nxt = RUN;
      default: nxt = RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RUN; cnt <= '0; gated <= 1'b0; done <= 1'b0;
      proto_err <= 1'b0; snp_pend <= 1'b0; irq_pend <= 1'b0;
    end else begin
      st <= nxt;
      done <= (nxt != st) && (nxt inside {RUN, SG, SLP, DSL});
      if (nxt == DSL && st != DSL)      cnt <= CW'(STOP_DLY - 1);
      else if (nxt == EXT && st != EXT) cnt <= CW'(PLL_CYC - 1);
      else if (cnt != '0)               cnt <= cnt - 1'b1;
      gated <= (nxt == DSL) && (gated || (st == DSL && cnt == '0 && cfg_clk_stop));
      proto_err <= !allow && (snoop_req || irq_req);
      snp_pend  <= !allow && (snp_pend || snoop_req);
      irq_pend  <= !allow && (irq_pend || irq_req);
    end
  end

  logic allow;
  assign allow = st inside {RUN, SGW, SG};

  assign stop_clk_req_n = st inside {RUN, RST};
  assign sleep_req_n    = !(st inside {SLP, DSL, EXT});
  assign deep_req_n     = st != DSL;
  assign bus_clk_en     = !gated;
  assign cpu_reset      = st == RST;
  assign snoop_fwd      = allow && (snoop_req || snp_pend);
  assign irq_fwd        = allow && (irq_req || irq_pend);
  assign running        = st == RUN;
  assign state_code     = (st == SG)  ? 2'b00 :
                          (st == SLP) ? 2'b01 :
                          (st == DSL) ? 2'b10 : 2'b11;
endmodule

module lp_state_seq_chk #(
  parameter int PLL_CYC  = 1500,
  parameter int STOP_DLY = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reset_req,
  input logic       snoop_req,
  input logic       irq_req,
  input logic       stop_clk_req_n,
  input logic       sleep_req_n,
  input logic       deep_req_n,
  input logic       bus_clk_en,
  input logic       cpu_reset,
  input logic       snoop_fwd,
  input logic       irq_fwd,
  input logic       proto_err,
  input logic [1:0] state_code
);
  int dcnt, xcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= 0; xcnt <= 0;
    end else begin
      dcnt <= deep_req_n ? 0 : dcnt + 1;
      xcnt <= (state_code == 2'b11 && !sleep_req_n && deep_req_n) ? xcnt + 1 : 0;
    end
  end

  assert_nest_deep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !deep_req_n |-> !sleep_req_n);
  assert_nest_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_req_n |-> !stop_clk_req_n);
  assert_sleep_from_sg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_req_n) |-> $past(state_code) == 2'b00);
  assert_deep_from_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(deep_req_n) |-> $past(state_code) == 2'b01);
  assert_clk_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_req_n) |-> bus_clk_en);
  assert_pll_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_code) == 2'b11 && state_code == 2'b01) |-> xcnt == PLL_CYC);
  assert_gate_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_clk_en) |-> dcnt == STOP_DLY);
  assert_gate_only_deep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clk_en |-> !deep_req_n);
  assert_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_req_n || cpu_reset) |-> !(snoop_fwd || irq_fwd));
  assert_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_req_n && (snoop_req || irq_req)) |=> proto_err);
  assert_reset_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_reset) |-> (stop_clk_req_n && sleep_req_n));
  assert_reset_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!deep_req_n && reset_req) |=> !cpu_reset);
endmodule

bind lp_state_seq lp_state_seq_chk #(.PLL_CYC(PLL_CYC), .STOP_DLY(STOP_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .snoop_req(snoop_req),
  .irq_req(irq_req), .stop_clk_req_n(stop_clk_req_n), .sleep_req_n(sleep_req_n),
  .deep_req_n(deep_req_n), .bus_clk_en(bus_clk_en), .cpu_reset(cpu_reset),
  .snoop_fwd(snoop_fwd), .irq_fwd(irq_fwd), .proto_err(proto_err),
  .state_code(state_code));

// File: tb/lp_state_seq_test.sv
module lp_state_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PLL = 1500;
  localparam int SDLY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pwr_req = 2'b00;
  logic stop_ack = 0, reset_req = 0, cfg_clk_stop = 1, snoop_req = 0, irq_req = 0;
  logic stop_clk_req_n, sleep_req_n, deep_req_n, bus_clk_en, cpu_reset;
  logic snoop_fwd, irq_fwd, proto_err, running, done;
  logic [1:0] state_code;

  int checks = 0, fails = 0, cycles = 0;
  logic [2:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_state_seq #(.PLL_CYC(PLL), .STOP_DLY(SDLY)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .stop_ack(stop_ack),
    .reset_req(reset_req), .cfg_clk_stop(cfg_clk_stop), .snoop_req(snoop_req),
    .irq_req(irq_req), .stop_clk_req_n(stop_clk_req_n), .sleep_req_n(sleep_req_n),
    .deep_req_n(deep_req_n), .bus_clk_en(bus_clk_en), .cpu_reset(cpu_reset),
    .snoop_fwd(snoop_fwd), .irq_fwd(irq_fwd), .proto_err(proto_err),
    .state_code(state_code), .running(running), .done(done));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: push the expected {state_code, running} then set the request
  task automatic go(input logic [1:0] lvl, input logic [2:0] expect_item);
    exp_q.push_back(expect_item);
    pwr_req = lvl;
  endtask

  // monitor: every done pulse must match the next expected item
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk("R8 unexpected done", 1, 0);
      else chk("R8 done state", {state_code, running}, exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1'b1; step(1);
    chk("R8 reset running", running, 1);
    chk("R8 reset code", state_code, 3);
    chk("R8 reset lines", {stop_clk_req_n, sleep_req_n, deep_req_n, bus_clk_en}, 15);

    // R1 entry to Stop-Grant waits for acknowledge
    go(2'b01, 3'b000); step(1);
    chk("R1 stpclk low", stop_clk_req_n, 0);
    chk("R1 waiting code", state_code, 3);
    step(3);
    chk("R1 no ack no SG", {state_code, running}, 6);
    stop_ack = 1; step(1);
    chk("R1 SG after ack", state_code, 0);
    stop_ack = 0;

    // R2 Sleep, R5 blocking
    go(2'b10, 3'b010); step(1);
    chk("R2 sleep line", sleep_req_n, 0);
    chk("R2 sleep code", state_code, 1);
    snoop_req = 1; #1;
    chk("R5 snoop blocked", snoop_fwd, 0);
    step(1); snoop_req = 0;
    chk("R5 proto_err", proto_err, 1);

    // R2 Deep Sleep, R4 gating
    go(2'b11, 3'b100); step(1);
    chk("R2 deep line", deep_req_n, 0);
    chk("R2 deep code", state_code, 2);
    chk("R4 clk on t1", bus_clk_en, 1);
    step(1); chk("R4 clk on t2", bus_clk_en, 1);
    step(1); chk("R4 clk off", bus_clk_en, 0);
    reset_req = 1; step(2);
    chk("R10 reset ignored deep", {cpu_reset, state_code}, 2);
    reset_req = 0;

    // R3 exit with R7 queued deeper request, R10 in wait
    go(2'b10, 3'b010); step(1);
    chk("R3 deep line released", deep_req_n, 1);
    chk("R3 clk restored", bus_clk_en, 1);
    chk("R3 wait code", state_code, 3);
    exp_q.push_back(3'b100); pwr_req = 2'b11;
    reset_req = 1; step(2); reset_req = 0;
    chk("R10 reset ignored wait", cpu_reset, 0);
    step(PLL - 3);
    chk("R3 R7 still waiting", state_code, 3);
    step(1); chk("R3 sleep reached", state_code, 1);
    step(1); chk("R7 queued deep", state_code, 2);

    // exit again, then R9 back to Stop-Grant with R5 release
    go(2'b10, 3'b010); step(PLL + 1);
    chk("R3 sleep again", state_code, 1);
    go(2'b01, 3'b000); step(1);
    chk("R9 SG from sleep", {state_code, sleep_req_n}, 1);
    chk("R5 pending snoop released", snoop_fwd, 1);
    step(1); chk("R5 released once", snoop_fwd, 0);

    // R4 clock left running
    cfg_clk_stop = 0;
    go(2'b10, 3'b010); step(1);
    go(2'b11, 3'b100); step(4);
    chk("R4 clock kept", bus_clk_en, 1);
    irq_req = 1; step(1); irq_req = 0;
    chk("R5 irq flagged deep", {proto_err, irq_fwd}, 2);
    go(2'b10, 3'b010); step(PLL + 1);
    chk("R3 sleep third", state_code, 1);

    // R6 reset from Sleep
    reset_req = 1; step(1);
    chk("R6 reset out", cpu_reset, 1);
    chk("R6 lines released", {stop_clk_req_n, sleep_req_n}, 3);
    chk("R6 code", state_code, 3);
    chk("R5 irq held in reset", irq_fwd, 0);
    pwr_req = 2'b00; exp_q.push_back(3'b111);
    reset_req = 0; step(1);
    chk("R6 straight to run", {running, cpu_reset}, 2);
    chk("R5 irq after reset", irq_fwd, 1);

    // R9 Stop-Grant back to running
    go(2'b01, 3'b000); stop_ack = 1; step(2); stop_ack = 0;
    chk("R9 SG", state_code, 0);
    go(2'b00, 3'b111); step(1);
    chk("R9 running", {running, stop_clk_req_n}, 3);

    step(2);
    chk("R8 all transitions seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule